// File: doc/BRIEF.md
# Fractional-N Divide Ratio Modulator

This block supplies the divide value that a PLL feedback counter loads at the start of each of its cycles. The value changes from cycle to cycle. Its long-run mean equals an integer part plus a fine fraction. A third-order cascade of three first-order accumulators turns the fractional remainder into a dither sequence whose error is pushed towards high offset frequencies.

The fraction is widened by one bit set to 1 below its least significant bit. The modulator therefore always works on an odd code of FRAC_W+1 bits, and its first accumulator runs through its full period of 2^(FRAC_W+1) steps. Every input is taken only in a cycle where `div_en` is high; that pulse comes once per feedback-divider cycle. The new divide value appears on `div_ratio` one clock after that edge and holds until the next enable.

A small state machine records the operating mode: idle after reset, integer-only, or fractional. In integer-only mode the output is exactly the integer part, and the accumulators and the correction history are cleared. On the next fractional enable the modulator therefore starts again from the same state it has after reset. The states are ST_IDLE, ST_INTEGER and ST_FRAC. Reset enters ST_IDLE. Any enable with `int_mode` high moves to ST_INTEGER. Any enable with `int_mode` low moves to ST_FRAC. Without an enable the state holds.

Top module: `frac_ratio_modulator`

## Requirements
- R1: After reset `div_ratio` is 0 and stays 0 until the first cycle with `div_en` high.
- R2: An enable with `int_mode` = 1 makes `div_ratio` equal to `ratio_int` (zero-extended) from the next clock. That value holds while further integer-mode enables use the same `ratio_int`.
- R3: In fractional mode, with `ratio_int` of at least 3, each output lies in the range `ratio_int` - 3 to `ratio_int` + 4.
- R4: The effective fraction is F = 2*`ratio_frac` + 1 over 2^(FRAC_W+1). After k fractional enables from a cleared state with constant inputs, the sum of the k outputs minus (k*`ratio_int` + floor(k*F / 2^(FRAC_W+1))) lies between -1 and +2.
- R5: Over exactly 2^(FRAC_W+1) fractional enables from a cleared state, the output sum lies within -1 to +2 of 2^(FRAC_W+1)*`ratio_int` + 2*`ratio_frac` + 1. This holds for fraction codes of 0 and of all ones.
- R6: In cycles without `div_en`, changes on `ratio_int`, `ratio_frac` and `int_mode` have no effect. `div_ratio` holds, and the later output sequence depends only on the values present at enables.
- R7: An integer-mode enable clears the modulator. The fractional sequence that follows it is identical to the one that follows reset for the same inputs.
- R8: `div_ratio` changes only on the clock edge after an enable cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_en | input | 1 | One pulse per feedback-divider cycle; advances the modulator |
| int_mode | input | 1 | 1 selects integer-only division with no dither |
| ratio_int | input | INT_W | Integer part of the divide ratio |
| ratio_frac | input | FRAC_W | Fraction code; a half LSB is added below it |
| div_ratio | output | OUT_W | Instantaneous divide value (OUT_W = INT_W + 1) |

## Verification
The bench builds the block with INT_W = 7 and FRAC_W = 10. The first accumulator is then 11 bits wide and completes its period in 2048 enables. Several full periods, including the all-zero and all-ones fraction codes and the integer extremes 3 and 127, fit into one short run, so the full-period sum of R5 is checked exactly as stated. The cumulative bound of R4 is checked after every enable along the way. Random idle gaps carry junk on the inputs and test R6 and R8. Repeated prefixes after reset and after integer mode test R7.

// File: rtl/frac_ratio_pkg.sv
package frac_ratio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_INTEGER = 2'd1,
        ST_FRAC    = 2'd2
    } mode_state_t;

    localparam int MASH_ORDER = 3;
    localparam int CORR_W     = 4;
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clear,
    input  logic [W-1:0] addend,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    logic [W-1:0] acc_q;
    logic [W:0]   total;

    always_comb begin
        total   = {1'b0, acc_q} + {1'b0, addend};
        sum_o   = total[W-1:0];
        carry_o = total[W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum_o;
        end
    end
endmodule

// File: rtl/mash_noise_combiner.sv
module mash_noise_combiner
    import frac_ratio_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic                     clear,
    input  logic [MASH_ORDER-1:0]    carry,
    output logic signed [CORR_W-1:0] corr
);
    logic c2_d1, c3_d1, c3_d2;

    always_comb begin
        corr = CORR_W'(carry[0])
             + CORR_W'(carry[1]) - CORR_W'(c2_d1)
             + CORR_W'(carry[2]) - (CORR_W'(c3_d1) << 1) + CORR_W'(c3_d2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else if (clear) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else if (step) begin
            c2_d1 <= carry[1];
            c3_d1 <= carry[2];
            c3_d2 <= c3_d1;
        end
    end
endmodule

// File: rtl/frac_ratio_modulator.sv
module frac_ratio_modulator
    import frac_ratio_pkg::*;
#(
    parameter int INT_W  = 7,
    parameter int FRAC_W = 18,
    parameter int OUT_W  = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_en,
    input  logic              int_mode,
    input  logic [INT_W-1:0]  ratio_int,
    input  logic [FRAC_W-1:0] ratio_frac,
    output logic [OUT_W-1:0]  div_ratio
);
    localparam int ACC_W = FRAC_W + 1;

    mode_state_t state_q, state_nx;
    logic [OUT_W-1:0] div_q, div_nx;
    logic [ACC_W-1:0] frac_ext;
    logic [ACC_W-1:0] stage_in  [MASH_ORDER];
    logic [ACC_W-1:0] stage_sum [MASH_ORDER];
    logic [MASH_ORDER-1:0] carries;
    logic signed [CORR_W-1:0] corr;
    logic frac_step, mod_clear;

    assign frac_ext  = {ratio_frac, 1'b1};
    assign frac_step = div_en && !int_mode;
    assign mod_clear = div_en && int_mode;

    for (genvar i = 0; i < MASH_ORDER; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stage_in[i] = frac_ext;
        end else begin : g_next
            assign stage_in[i] = stage_sum[i-1];
        end
        mash_acc_stage #(.W(ACC_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (frac_step),
            .clear   (mod_clear),
            .addend  (stage_in[i]),
            .sum_o   (stage_sum[i]),
            .carry_o (carries[i])
        );
    end

    mash_noise_combiner u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (frac_step),
        .clear (mod_clear),
        .carry (carries),
        .corr  (corr)
    );

    always_comb begin
        state_nx = state_q;
        if (div_en) begin
            state_nx = int_mode ? ST_INTEGER : ST_FRAC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        div_nx = div_q;
        if (div_en) begin
            unique case (state_nx)
                ST_INTEGER: div_nx = OUT_W'(ratio_int);
                ST_FRAC:    div_nx = OUT_W'(ratio_int)
                                   + {{(OUT_W-CORR_W){corr[CORR_W-1]}}, corr};
                ST_IDLE:    div_nx = div_q;
                default:    div_nx = div_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_nx;
        end
    end

    assign div_ratio = div_q;
endmodule

// File: rtl/frac_ratio_checker.sv
module frac_ratio_checker
    import frac_ratio_pkg::*;
#(
    parameter int INT_W = 7,
    parameter int OUT_W = INT_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_en,
    input logic             int_mode,
    input logic [INT_W-1:0] ratio_int,
    input logic [OUT_W-1:0] div_ratio,
    input mode_state_t      state_q
);
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (div_ratio == '0));

    assert_int_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && int_mode) |=> (div_ratio == OUT_W'($past(ratio_int))));

    assert_frac_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && !int_mode && ratio_int >= INT_W'(3)) |=>
        ((int'(div_ratio) >= int'($past(ratio_int)) - 3) &&
         (int'(div_ratio) <= int'($past(ratio_int)) + 4)));

    assert_hold_no_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !div_en |=> $stable(div_ratio));
endmodule

bind frac_ratio_modulator frac_ratio_checker #(.INT_W(INT_W), .OUT_W(OUT_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_en    (div_en),
    .int_mode  (int_mode),
    .ratio_int (ratio_int),
    .div_ratio (div_ratio),
    .state_q   (state_q)
);

// File: tb/tb_frac_ratio_modulator.sv
module tb_frac_ratio_modulator;
    localparam int INT_W  = 7;
    localparam int FRAC_W = 10;
    localparam int OUT_W  = INT_W + 1;
    localparam int ACC_W  = FRAC_W + 1;
    localparam int PERIOD = 1 << ACC_W;
    localparam int PREFIX = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic div_en = 1'b0;
    logic int_mode = 1'b0;
    logic [INT_W-1:0]  ratio_int = '0;
    logic [FRAC_W-1:0] ratio_frac = '0;
    logic [OUT_W-1:0]  div_ratio;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    int ref_prefix [PREFIX];
    int cur_prefix [PREFIX];

    always #2 clk = ~clk;

    frac_ratio_modulator #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_en     (div_en),
        .int_mode   (int_mode),
        .ratio_int  (ratio_int),
        .ratio_frac (ratio_frac),
        .div_ratio  (div_ratio)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint floor_part(input longint k, input longint f);
        return (k * f) >> ACC_W;
    endfunction

    // idle cycles with junk on the inputs; output must hold (R6, R8)
    task automatic idle_gap(input int cycles);
        for (int g = 0; g < cycles; g++) begin
            logic [OUT_W-1:0] held;
            @(negedge clk);
            held = div_ratio;
            div_en = 1'b0;
            ratio_int = INT_W'($urandom);
            ratio_frac = FRAC_W'($urandom);
            int_mode = 1'($urandom);
            @(posedge clk); #1;
            check(div_ratio == held, "R6", div_ratio, held);
        end
    endtask

    task automatic enable_once(input bit im, input int m, input int f, output int val);
        @(negedge clk);
        div_en = 1'b1;
        int_mode = im;
        ratio_int = INT_W'(m);
        ratio_frac = FRAC_W'(f);
        @(posedge clk); #1;
        val = int'(div_ratio);
        div_en = 1'b0;
    endtask

    // fractional run from cleared state; checks R3, R4 per enable, R5 at full period
    task automatic frac_run(input int m, input int f, input int n, input bit gaps);
        longint sum = 0;
        longint eff = 2 * longint'(f) + 1;
        for (int k = 1; k <= n; k++) begin
            int v;
            longint d;
            if (gaps && ($urandom % 3 == 0)) idle_gap(1 + ($urandom % 2));
            enable_once(1'b0, m, f, v);
            if (k <= PREFIX) cur_prefix[k-1] = v;
            check((v >= m - 3) && (v <= m + 4), "R3", v, m);
            sum += v;
            d = sum - (longint'(k) * m + floor_part(k, eff));
            check((d >= -1) && (d <= 2), "R4", d, 0);
        end
        if (n == PERIOD) begin
            longint d5 = sum - (longint'(PERIOD) * m + eff);
            check((d5 >= -1) && (d5 <= 2), "R5", sum, longint'(PERIOD) * m + eff);
        end
    endtask

    task automatic clear_by_int(input int m);
        int v;
        enable_once(1'b1, m, 0, v);
        check(v == m, "R2", v, m);
    endtask

    initial begin
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(posedge clk);
        #1;
        check(div_ratio == '0, "R1", div_ratio, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_gap(4);
        check(div_ratio == '0, "R1", div_ratio, 0);

        // reference prefix straight after reset (R7)
        frac_run(50, 333, PREFIX, 1'b0);
        foreach (cur_prefix[i]) ref_prefix[i] = cur_prefix[i];

        // integer mode, directed and random (R2)
        clear_by_int(127);
        clear_by_int(0);
        for (int i = 0; i < 6; i++) begin
            int m = $urandom % 128;
            int v;
            clear_by_int(m);
            enable_once(1'b1, m, $urandom, v);
            check(v == m, "R2", v, m);
        end

        // same prefix after integer-mode clear (R7)
        frac_run(50, 333, PREFIX, 1'b1);
        foreach (cur_prefix[i]) check(cur_prefix[i] == ref_prefix[i], "R7", cur_prefix[i], ref_prefix[i]);

        // full-period corners (R5)
        clear_by_int(3);
        frac_run(3, 0, PERIOD, 1'b1);
        clear_by_int(127);
        frac_run(127, (1 << FRAC_W) - 1, PERIOD, 1'b0);
        clear_by_int(3);
        frac_run(3, (1 << FRAC_W) - 1, PERIOD, 1'b1);

        // random settings (R4, R5)
        for (int r = 0; r < 4; r++) begin
            int m = 3 + ($urandom % 125);
            int f = $urandom % (1 << FRAC_W);
            clear_by_int(m);
            frac_run(m, f, PERIOD, 1'b1);
        end

        // partial run then integer hold (R2, R8)
        clear_by_int(20);
        frac_run(20, 512, 100, 1'b1);
        clear_by_int(20);
        idle_gap(3);
        check(div_ratio == OUT_W'(20), "R8", div_ratio, 20);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule